// File: doc/BRIEF.md
# Caller-ID Demodulator Power Sequencer

This controller decides when an external FSK demodulator on a telephone-line receiver is powered. At rest it holds the demodulator off to save battery. A ring indication or a key press wakes it. It then powers the demodulator up and forwards each received byte to the host. Once the carrier-detect and data-detect lines have both been inactive for a long idle period, it powers the demodulator down again. The idle period is counted in ticks of the slow sub-clock.

The same block holds an 8-bit control/status register with three bits. One bit shows battery health. One bit enables the low-battery comparator. One bit chooses between the fast PLL clock and the slow sub-clock. Clock changes use a break-before-make handover, so the two clock enables are never high together.

Top module: `cid_power_seq`

## Requirements
- R1: After reset, demodPwrEn is 0, hostValid is 0, cmpPwrEn is 0, slowClkEn is 1, fastClkEn is 0, and regRdData reads 8'h10.
- R2: While powered down, a 0 on ringTimeN powers the demodulator up. demodPwrEn reads 1 after the third rising edge following the input change (two synchronizer stages plus the state register).
- R3: While powered down, any 1 bit on keyIn powers the demodulator up, with the same three-edge latency as R2.
- R4: While powered up, the block stays powered for as long as ringDetN or carrDetN is 0, however many subTick pulses arrive.
- R5: With both detect lines at 1, no key held and no byte forwarded, demodPwrEn drops to 0 on the edge that samples the IDLE_TICKS-th subTick pulse. A key press, a 0 on either detect line, or a forwarded byte restarts that count from zero.
- R6: While powered up, a byte presented with rxValid appears on hostData with hostValid high one edge later. While powered down, rxValid is ignored and hostValid stays 0.
- R7: Register layout: bit 4 is the read-only battery status, bit 5 is the detect enable and drives cmpPwrEn, bit 6 is the clock select (1 = fast PLL clock). All other bits read 0, and writes to bit 4 have no effect.
- R8: With the detect enable at 1, bit 4 follows battCmpOk (0 = low battery) one edge later. With the detect enable at 0, bit 4 reads 1.
- R9: A write that changes the clock select drops the old clock enable one edge after the write edge and raises the new one an edge after that. fastClkEn and slowClkEn are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ringTimeN | input | 1 | Ring indication, active low, asynchronous |
| keyIn | input | KEYS | External key inputs, active high, asynchronous |
| ringDetN | input | 1 | Demodulator data-detect line, active low, asynchronous |
| carrDetN | input | 1 | Demodulator carrier-detect line, active low, asynchronous |
| subTick | input | 1 | One-cycle pulse for each sub-clock period |
| rxValid | input | 1 | Byte from the demodulator is valid |
| rxData | input | DATA_W | Byte from the demodulator |
| battCmpOk | input | 1 | Battery comparator result, 1 = normal |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| demodPwrEn | output | 1 | Demodulator power enable, 1 = powered |
| hostValid | output | 1 | Forwarded byte valid |
| hostData | output | DATA_W | Forwarded byte |
| cmpPwrEn | output | 1 | Battery comparator power control |
| fastClkEn | output | 1 | Enable for the PLL clock path |
| slowClkEn | output | 1 | Enable for the sub-clock path |

## Verification
The assertions assume that subTick, rxValid and the register write port are synchronous to clk. They also assume that the asynchronous lines change far less often than the synchronizer depth, so a change always settles before the state machine acts on it. The stimulus changes every input on the falling edge, and it keeps ring, key and detect changes at least three cycles apart from any subTick pulse. Each idle-count boundary therefore lands on a known edge. The idle period is shortened to 8 ticks so that both the expiry edge and the restart edge can be checked exactly.

// File: rtl/cid_pwr_pkg.sv
package cid_pwr_pkg;

  localparam int REG_W      = 8;
  localparam int STAT_BIT   = 4;
  localparam int DETEN_BIT  = 5;
  localparam int CLKSEL_BIT = 6;

  typedef enum logic {
    PH_SLEEP = 1'b0,
    PH_AWAKE = 1'b1
  } phase_e;

  typedef struct packed {
    logic pwrOn;
    logic rxAccept;
  } ctrl_strb_t;

endpackage

// File: rtl/cid_sync.sv
module cid_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic stage1;
    logic stage2;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1 <= RST_VAL[i];
        stage2 <= RST_VAL[i];
      end else begin
        stage1 <= d[i];
        stage2 <= stage1;
      end
    end
    assign q[i] = stage2;
  end

endmodule

// File: rtl/cid_pwr_ctrl.sv
module cid_pwr_ctrl
  import cid_pwr_pkg::*;
#(
  parameter int KEYS       = 4,
  parameter int IDLE_TICKS = 983040
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ringTimeN,
  input  logic [KEYS-1:0] keyIn,
  input  logic            ringDetN,
  input  logic            carrDetN,
  input  logic            subTick,
  input  logic            byteXfer,
  output ctrl_strb_t      strb
);

  localparam int SW = KEYS + 3;
  localparam int CW = $clog2(IDLE_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_TICKS - 1);
  localparam logic [SW-1:0] SYNC_RST = {3'b111, {KEYS{1'b0}}};

  logic [SW-1:0] syncQ;
  logic          sRingTimeN;
  logic          sRingDetN;
  logic          sCarrDetN;
  logic          keyAny;
  logic          wakeSrc;
  logic          activity;
  phase_e        phase;
  logic [CW-1:0] idleCnt;

  cid_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .d   ({ringTimeN, ringDetN, carrDetN, keyIn}),
    .q   (syncQ)
  );

  assign sRingTimeN = syncQ[KEYS+2];
  assign sRingDetN  = syncQ[KEYS+1];
  assign sCarrDetN  = syncQ[KEYS];
  assign keyAny     = |syncQ[KEYS-1:0];

  assign wakeSrc  = !sRingTimeN || keyAny;
  assign activity = !sRingDetN || !sCarrDetN || keyAny || byteXfer;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_SLEEP;
      idleCnt <= '0;
    end else begin
      unique case (phase)
        PH_SLEEP: begin
          idleCnt <= '0;
          if (wakeSrc) phase <= PH_AWAKE;
        end
        PH_AWAKE: begin
          if (activity) begin
            idleCnt <= '0;
          end else if (subTick) begin
            if (idleCnt == LAST) begin
              phase   <= PH_SLEEP;
              idleCnt <= '0;
            end else begin
              idleCnt <= idleCnt + 1'b1;
            end
          end
        end
        default: phase <= PH_SLEEP;
      endcase
    end
  end

  assign strb.pwrOn    = (phase == PH_AWAKE);
  assign strb.rxAccept = (phase == PH_AWAKE);

  AST_STAY_ASLEEP: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_SLEEP && !wakeSrc) |=> (phase == PH_SLEEP)); // R2
  AST_HOLD_ON_DETECT: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_AWAKE && (!sRingDetN || !sCarrDetN)) |=> (phase == PH_AWAKE)); // R4
  AST_SLEEP_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb.pwrOn) |-> $past(idleCnt == LAST && subTick && !activity)); // R5

endmodule

// File: rtl/cid_pwr_dp.sv
module cid_pwr_dp
  import cid_pwr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strb_t        strb,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic              battCmpOk,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              hostValid,
  output logic [DATA_W-1:0] hostData,
  output logic              cmpPwrEn,
  output logic              fastClkEn,
  output logic              slowClkEn
);

  logic detEn;
  logic clkSel;
  logic lowBatOk;
  logic unusedWrBits;

  assign unusedWrBits = ^{regWrData[7], regWrData[STAT_BIT:0]};

  // Register bits that software can write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      detEn  <= 1'b0;
      clkSel <= 1'b0;
    end else if (regWrEn) begin
      detEn  <= regWrData[DETEN_BIT];
      clkSel <= regWrData[CLKSEL_BIT];
    end
  end

  // Battery status, forced to normal while detection is off
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowBatOk <= 1'b1;
    else       lowBatOk <= detEn ? battCmpOk : 1'b1;
  end

  assign cmpPwrEn = detEn;

  always_comb begin
    regRdData             = '0;
    regRdData[STAT_BIT]   = lowBatOk;
    regRdData[DETEN_BIT]  = detEn;
    regRdData[CLKSEL_BIT] = clkSel;
  end

  // Break-before-make clock handover
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fastClkEn <= 1'b0;
      slowClkEn <= 1'b1;
    end else if (clkSel) begin
      if (slowClkEn) slowClkEn <= 1'b0;
      else           fastClkEn <= 1'b1;
    end else begin
      if (fastClkEn) fastClkEn <= 1'b0;
      else           slowClkEn <= 1'b1;
    end
  end

  // Byte forwarding to the host
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostValid <= 1'b0;
      hostData  <= '0;
    end else begin
      hostValid <= rxValid && strb.rxAccept;
      if (rxValid && strb.rxAccept) hostData <= rxData;
    end
  end

  AST_CLK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(fastClkEn && slowClkEn)); // R9
  AST_HOST_GATED: assert property (@(posedge clk) disable iff (!rstN)
    hostValid |-> $past(rxValid && strb.rxAccept)); // R6
  AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    $past(!detEn) |-> lowBatOk); // R8
  AST_SEL_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (clkSel == $past(regWrData[CLKSEL_BIT]))); // R7

endmodule

// File: rtl/cid_power_seq.sv
module cid_power_seq
  import cid_pwr_pkg::*;
#(
  parameter int KEYS       = 4,
  parameter int DATA_W     = 8,
  parameter int IDLE_TICKS = 983040
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ringTimeN,
  input  logic [KEYS-1:0]   keyIn,
  input  logic              ringDetN,
  input  logic              carrDetN,
  input  logic              subTick,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic              battCmpOk,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  output logic              demodPwrEn,
  output logic              hostValid,
  output logic [DATA_W-1:0] hostData,
  output logic              cmpPwrEn,
  output logic              fastClkEn,
  output logic              slowClkEn
);

  ctrl_strb_t strb;

  cid_pwr_ctrl #(.KEYS(KEYS), .IDLE_TICKS(IDLE_TICKS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ringTimeN(ringTimeN),
    .keyIn    (keyIn),
    .ringDetN (ringDetN),
    .carrDetN (carrDetN),
    .subTick  (subTick),
    .byteXfer (hostValid),
    .strb     (strb)
  );

  cid_pwr_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rxValid  (rxValid),
    .rxData   (rxData),
    .battCmpOk(battCmpOk),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .hostValid(hostValid),
    .hostData (hostData),
    .cmpPwrEn (cmpPwrEn),
    .fastClkEn(fastClkEn),
    .slowClkEn(slowClkEn)
  );

  assign demodPwrEn = strb.pwrOn;

endmodule

// File: tb/tb_cid_power_seq.sv
`timescale 1ns/1ps
module tb_cid_power_seq;

  localparam int KEYS  = 4;
  localparam int DW    = 8;
  localparam int IDLE  = 8;
  localparam int NVEC  = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          ringTimeN = 1'b1;
  logic [KEYS-1:0] keyIn = '0;
  logic          ringDetN = 1'b1;
  logic          carrDetN = 1'b1;
  logic          subTick = 1'b0;
  logic          rxValid = 1'b0;
  logic [DW-1:0] rxData = '0;
  logic          battCmpOk = 1'b1;
  logic          regWrEn = 1'b0;
  logic [7:0]    regWrData = '0;
  logic [7:0]    regRdData;
  logic          demodPwrEn;
  logic          hostValid;
  logic [DW-1:0] hostData;
  logic          cmpPwrEn;
  logic          fastClkEn;
  logic          slowClkEn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // {write data, comparator value, expected readback}
  localparam logic [16:0] VEC [NVEC] = '{
    {8'h00, 1'b0, 8'h10},
    {8'h20, 1'b0, 8'h20},
    {8'h20, 1'b1, 8'h30},
    {8'hFF, 1'b0, 8'h60},
    {8'h5F, 1'b0, 8'h50},
    {8'h10, 1'b0, 8'h10}
  };

  cid_power_seq #(.KEYS(KEYS), .DATA_W(DW), .IDLE_TICKS(IDLE)) dut (
    .clk(clk), .rstN(rstN), .ringTimeN(ringTimeN), .keyIn(keyIn),
    .ringDetN(ringDetN), .carrDetN(carrDetN), .subTick(subTick),
    .rxValid(rxValid), .rxData(rxData), .battCmpOk(battCmpOk),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .demodPwrEn(demodPwrEn), .hostValid(hostValid), .hostData(hostData),
    .cmpPwrEn(cmpPwrEn), .fastClkEn(fastClkEn), .slowClkEn(slowClkEn)
  );

  always #2.5 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulseTicks(input int n);
    for (int i = 0; i < n; i++) begin
      subTick = 1'b1;
      tick(1);
      subTick = 1'b0;
      tick(1);
    end
  endtask

  task automatic regWrite(input logic [7:0] d);
    regWrData = d;
    regWrEn   = 1'b1;
    tick(1);
    regWrEn   = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);

    // R1 reset state
    check("R1 demodPwrEn", demodPwrEn, 0);
    check("R1 hostValid", hostValid, 0);
    check("R1 cmpPwrEn", cmpPwrEn, 0);
    check("R1 slowClkEn", slowClkEn, 1);
    check("R1 fastClkEn", fastClkEn, 0);
    check("R1 regRdData", regRdData, 8'h10);

    // R7 R8 register vectors
    for (int v = 0; v < NVEC; v++) begin
      battCmpOk = VEC[v][8];
      regWrite(VEC[v][16:9]);
      tick(1);
      check("R7 R8 readback", regRdData, VEC[v][7:0]);
      check("R7 cmpPwrEn", cmpPwrEn, VEC[v][5]);
    end
    battCmpOk = 1'b1;
    tick(4);

    // R9 clock handover to fast, then back
    regWrite(8'h40);
    check("R9 old slow still on", {slowClkEn, fastClkEn}, 2'b10);
    tick(1);
    check("R9 break gap", {slowClkEn, fastClkEn}, 2'b00);
    tick(1);
    check("R9 fast on", {slowClkEn, fastClkEn}, 2'b01);
    regWrite(8'h00);
    check("R9 old fast still on", {slowClkEn, fastClkEn}, 2'b01);
    tick(1);
    check("R9 break gap back", {slowClkEn, fastClkEn}, 2'b00);
    tick(1);
    check("R9 slow on", {slowClkEn, fastClkEn}, 2'b10);

    // R6 byte ignored while asleep
    rxData = 8'h3C; rxValid = 1'b1;
    tick(1);
    rxValid = 1'b0;
    check("R6 no forward asleep", hostValid, 0);

    // R2 wake on ring
    ringTimeN = 1'b0;
    tick(2);
    check("R2 not yet awake", demodPwrEn, 0);
    tick(1);
    check("R2 awake", demodPwrEn, 1);
    ringTimeN = 1'b1;
    tick(3);

    // R5 idle expiry
    pulseTicks(IDLE - 1);
    check("R5 awake before last tick", demodPwrEn, 1);
    subTick = 1'b1;
    tick(1);
    subTick = 1'b0;
    check("R5 asleep at last tick", demodPwrEn, 0);
    tick(2);

    // R3 wake on key
    keyIn = 4'b0100;
    tick(2);
    check("R3 not yet awake", demodPwrEn, 0);
    tick(1);
    check("R3 awake", demodPwrEn, 1);
    keyIn = '0;
    tick(3);

    // R6 forwarding and R5 restart by byte
    pulseTicks(5);
    rxData = 8'hA5; rxValid = 1'b1;
    tick(1);
    rxValid = 1'b0;
    check("R6 hostValid", hostValid, 1);
    check("R6 hostData", hostData, 8'hA5);
    tick(1);
    check("R6 hostValid drops", hostValid, 0);
    pulseTicks(IDLE - 1);
    check("R5 byte restarted count", demodPwrEn, 1);
    pulseTicks(1);
    check("R5 asleep after restart", demodPwrEn, 0);
    tick(2);

    // R4 carrier detect holds power; R5 restart by key
    keyIn = 4'b0001;
    tick(3);
    keyIn = '0;
    carrDetN = 1'b0;
    tick(3);
    pulseTicks(3 * IDLE);
    check("R4 carrier holds power", demodPwrEn, 1);
    carrDetN = 1'b1;
    ringDetN = 1'b0;
    tick(3);
    pulseTicks(2 * IDLE);
    check("R4 ring detect holds power", demodPwrEn, 1);
    ringDetN = 1'b1;
    tick(3);
    pulseTicks(4);
    keyIn = 4'b1000;
    tick(3);
    keyIn = '0;
    tick(3);
    pulseTicks(IDLE - 1);
    check("R5 key restarted count", demodPwrEn, 1);
    pulseTicks(1);
    check("R5 asleep after key restart", demodPwrEn, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule